// File: doc/BRIEF.md
# Transmitter Inter-Frame Gap and Line-Hold Sequencer

This block sets the timing envelope of a multi-frame serial transmission. The bit encoder offers each frame through a valid/ready handshake. Once the frame's payload bits are out, the encoder reports that the frame is done. The sequencer then asks the encoder for fill bits, one per bit-time strobe. Every frame is followed by a fixed set of mandatory fill bits. Between frames of the same message, a programmable number of extra fill bits is added.

The gap register holds the ones-complement of the extra-bit count, so an all-ones value means no extra bits. After the last frame, no extra fill bits are sent. Instead, the line-driver-active output stays high for a programmable hold time and then falls, which returns the block to idle. The hold field counts in steps of four transmit-clock cycles.

Back-pressure on the frame interface works as follows. `frm_ready` is high only while the block is idle, or while it sits between two frames of a message after the gap has ended. A frame is taken on a clock edge where `frm_valid` and `frm_ready` are both high. The producer must hold `frm_valid` and `frm_last` steady until that edge. Both configuration registers are captured when the first frame of a message is taken.

Top module: `gs_gap_hold_seq`

## Requirements
- R1: After reset, `tx_active` and `fill_req` are low and `frm_ready` is high.
- R2: On the cycle after a frame is accepted, `tx_active` is high and `frm_ready` is low. `tx_active` stays high through the frame, its fill bits, any gap and the hold time.
- R3: After `frm_done` is pulsed for an accepted frame, `fill_req` stays high for exactly 3 `bit_tick` strobes of mandatory fill, and for more strobes only as R4 allows.
- R4: For a frame accepted with `frm_last`=0, the mandatory fill is followed without a break by 255 − `gap_cfg` extra fill strobes. `gap_cfg`=8'hFF gives 0 extra strobes and 8'h00 gives 255.
- R5: For a frame accepted with `frm_last`=1, no extra fill is sent. `tx_active` stays high for `hold_cfg`×4 clock cycles after the edge that consumes the third fill strobe, then goes low. With `hold_cfg`=0 it is low on the cycle right after that edge.
- R6: `frm_ready` stays low during a frame, its fill bits and the extra-fill gap. A frame held valid during the gap is accepted only on the first edge after the gap has expired.
- R7: `gap_cfg` and `hold_cfg` are sampled when the first frame of a message is accepted. Changes made during a message take effect from the next message.
- R8: A `frm_done` pulse while no frame is being serialized (idle, or between frames) has no effect: `fill_req` stays low and `tx_active` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe per bit time from the encoder; consumes one requested fill bit |
| frm_valid | input | 1 | A frame is ready to be serialized |
| frm_last | input | 1 | The offered frame ends the message; qualified by `frm_valid` |
| frm_ready | output | 1 | The sequencer accepts the offered frame on this edge |
| frm_done | input | 1 | One-cycle pulse: the payload bits of the current frame are finished |
| gap_cfg | input | GAP_W (8) | Ones-complement of the extra fill-bit count between frames |
| hold_cfg | input | HOLD_W (5) | Line hold after the message, in steps of 4 clock cycles |
| fill_req | output | 1 | The encoder is to send fill bits on coming bit strobes |
| tx_active | output | 1 | Line driver enable |

## Verification
The assertions assume that `frm_done` is pulsed only once per accepted frame, while that frame is being serialized, and that `bit_tick` is a single-cycle strobe. The counter's no-underflow check depends on both. The bench issues exactly one `frm_done` pulse after each accepted frame and before any strobe. It drives `bit_tick` only while it sees `fill_req` high. Stray `frm_done` pulses appear only in the idle and between-frame states, which is where R8 says they must be ignored. `frm_valid` and `frm_last` are held until the accepting edge.

// File: rtl/gs_seq_pkg.sv
package gs_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FRAME,
    ST_MFILL,
    ST_GAP,
    ST_WAIT,
    ST_HOLD
  } gs_state_e;

  function automatic int unsigned gs_max3(input int unsigned a, input int unsigned b,
                                          input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/gs_cfg_snap.sv
module gs_cfg_snap #(
  parameter int unsigned GAP_W     = 8,
  parameter int unsigned HOLD_W    = 5,
  parameter int unsigned HOLD_STEP = 4,
  parameter int unsigned CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [GAP_W-1:0]  gap_in,
  input  logic [HOLD_W-1:0] hold_in,
  output logic [CNT_W-1:0]  extra_cnt,
  output logic [CNT_W-1:0]  hold_cyc
);

  logic [GAP_W-1:0]  gap_q;
  logic [HOLD_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q  <= '1;
      hold_q <= '0;
    end else if (capture) begin
      gap_q  <= gap_in;
      hold_q <= hold_in;
    end
  end

  // stored value is ones-complement of the wanted extra count
  assign extra_cnt = CNT_W'(~gap_q);
  assign hold_cyc  = CNT_W'(hold_q) * CNT_W'(HOLD_STEP);

endmodule

// File: rtl/gs_down_cnt.sv
module gs_down_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         cnt_one
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - 1'b1;
  end

  assign cnt_one = (cnt == W'(1));

  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> (cnt != '0));

endmodule

// File: rtl/gs_seq_fsm.sv
module gs_seq_fsm
  import gs_seq_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned MAND_FILL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             frm_valid,
  input  logic             frm_last,
  input  logic             frm_done,
  input  logic             cnt_one,
  input  logic [CNT_W-1:0] extra_cnt,
  input  logic [CNT_W-1:0] hold_cyc,
  output logic             frm_ready,
  output logic             fill_req,
  output logic             tx_active,
  output logic             capture,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             cnt_dec
);

  gs_state_e st, st_nxt;
  logic      last_q;
  logic      accept;

  assign frm_ready = (st == ST_IDLE) || (st == ST_WAIT);
  assign accept    = frm_valid && frm_ready;
  assign fill_req  = (st == ST_MFILL) || (st == ST_GAP);
  assign tx_active = (st != ST_IDLE);

  always_comb begin
    st_nxt   = st;
    capture  = 1'b0;
    cnt_load = 1'b0;
    cnt_val  = '0;
    cnt_dec  = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (accept) begin
          capture = 1'b1;
          st_nxt  = ST_FRAME;
        end
      end
      ST_FRAME: begin
        if (frm_done) begin
          st_nxt   = ST_MFILL;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(MAND_FILL);
        end
      end
      ST_MFILL: begin
        if (bit_tick) begin
          cnt_dec = 1'b1;
          if (cnt_one) begin
            if (last_q) begin
              if (hold_cyc == '0) begin
                st_nxt = ST_IDLE;
              end else begin
                st_nxt   = ST_HOLD;
                cnt_load = 1'b1;
                cnt_val  = hold_cyc;
              end
            end else if (extra_cnt == '0) begin
              st_nxt = ST_WAIT;
            end else begin
              st_nxt   = ST_GAP;
              cnt_load = 1'b1;
              cnt_val  = extra_cnt;
            end
          end
        end
      end
      ST_GAP: begin
        if (bit_tick) begin
          cnt_dec = 1'b1;
          if (cnt_one) st_nxt = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (accept) st_nxt = ST_FRAME;
      end
      ST_HOLD: begin
        cnt_dec = 1'b1;
        if (cnt_one) st_nxt = ST_IDLE;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      last_q <= 1'b0;
    end else begin
      st <= st_nxt;
      if (accept) last_q <= frm_last;
    end
  end

  // R5: a last frame never enters the inter-frame gap
  a_r5_last_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MFILL && bit_tick && cnt_one && last_q) |=> (st == ST_HOLD || st == ST_IDLE));

  a_r5_hold_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD && cnt_one) |=> (st == ST_IDLE));

  // R6: a frame offered during the gap is not started
  a_r6_gap_holds_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GAP && frm_valid) |=> (st != ST_FRAME));

  a_r8_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && frm_done && !frm_valid) |=> (st == ST_WAIT));

endmodule

// File: rtl/gs_gap_hold_seq.sv
module gs_gap_hold_seq
  import gs_seq_pkg::*;
#(
  parameter int unsigned GAP_W     = 8,
  parameter int unsigned HOLD_W    = 5,
  parameter int unsigned HOLD_STEP = 4,
  parameter int unsigned MAND_FILL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              frm_valid,
  input  logic              frm_last,
  output logic              frm_ready,
  input  logic              frm_done,
  input  logic [GAP_W-1:0]  gap_cfg,
  input  logic [HOLD_W-1:0] hold_cfg,
  output logic              fill_req,
  output logic              tx_active
);

  localparam int unsigned HOLD_PW = HOLD_W + $clog2(HOLD_STEP + 1);
  localparam int unsigned MAND_W  = $clog2(MAND_FILL + 1);
  localparam int unsigned CNT_W   = gs_max3(GAP_W, HOLD_PW, MAND_W);

  logic             capture;
  logic             cnt_load;
  logic             cnt_dec;
  logic             cnt_one;
  logic [CNT_W-1:0] cnt_val;
  logic [CNT_W-1:0] extra_cnt;
  logic [CNT_W-1:0] hold_cyc;

  gs_cfg_snap #(
    .GAP_W(GAP_W), .HOLD_W(HOLD_W), .HOLD_STEP(HOLD_STEP), .CNT_W(CNT_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .capture(capture),
    .gap_in(gap_cfg), .hold_in(hold_cfg),
    .extra_cnt(extra_cnt), .hold_cyc(hold_cyc)
  );

  gs_down_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
    .dec(cnt_dec), .cnt_one(cnt_one)
  );

  gs_seq_fsm #(.CNT_W(CNT_W), .MAND_FILL(MAND_FILL)) u_fsm (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frm_valid(frm_valid),
    .frm_last(frm_last), .frm_done(frm_done), .cnt_one(cnt_one),
    .extra_cnt(extra_cnt), .hold_cyc(hold_cyc), .frm_ready(frm_ready),
    .fill_req(fill_req), .tx_active(tx_active), .capture(capture),
    .cnt_load(cnt_load), .cnt_val(cnt_val), .cnt_dec(cnt_dec)
  );

  // R7: the captured configuration is frozen while a message runs
  a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && $past(tx_active)) |-> ($stable(extra_cnt) && $stable(hold_cyc)));

  a_r3_fill_inside_active: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> tx_active);

endmodule

// File: tb/tb_gs_gap_hold_seq.sv
module tb_gs_gap_hold_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       frm_valid = 1'b0;
  logic       frm_last = 1'b0;
  logic       frm_done = 1'b0;
  logic [7:0] gap_cfg = 8'hFF;
  logic [4:0] hold_cfg = 5'd0;
  logic       frm_ready, fill_req, tx_active;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  gs_gap_hold_seq dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frm_valid(frm_valid),
    .frm_last(frm_last), .frm_ready(frm_ready), .frm_done(frm_done),
    .gap_cfg(gap_cfg), .hold_cfg(hold_cfg), .fill_req(fill_req),
    .tx_active(tx_active)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic last);
    int guard = 0;
    while (!frm_ready && guard < 1000) begin @(negedge clk); guard++; end
    frm_valid = 1'b1;
    frm_last  = last;
    @(negedge clk);
    frm_valid = 1'b0;
    frm_last  = 1'b0;
  endtask

  task automatic pulse_done();
    frm_done = 1'b1;
    @(negedge clk);
    frm_done = 1'b0;
  endtask

  // drives one strobe per cycle while fill is requested
  task automatic count_fills(output int n, output int ready_seen);
    n = 0;
    ready_seen = 0;
    for (int i = 0; i < 1000; i++) begin
      if (!fill_req) break;
      if (frm_ready) ready_seen++;
      bit_tick = 1'b1;
      n++;
      @(negedge clk);
    end
    bit_tick = 1'b0;
  endtask

  task automatic count_hold(output int n);
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      if (!tx_active) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R1 tx_active", tx_active, 0);
    check("R1 fill_req", fill_req, 0);
    check("R1 frm_ready", frm_ready, 1);
  endtask

  task automatic t_single_last(input logic [4:0] h);
    int n, r;
    hold_cfg = h;
    send_frame(1'b1);
    check("R2 tx_active after accept", tx_active, 1);
    check("R2 frm_ready low in frame", frm_ready, 0);
    repeat (3) @(negedge clk);
    check("R2 tx_active during frame", tx_active, 1);
    pulse_done();
    count_fills(n, r);
    check("R3/R5 fill count last frame", n, 3);
    count_hold(n);
    check("R5 hold cycles", n, int'(h) * 4);
    check("R5 idle ready", frm_ready, 1);
  endtask

  task automatic t_two_frames(input logic [7:0] g, input logic [4:0] h);
    int n, r;
    gap_cfg = g;
    hold_cfg = h;
    send_frame(1'b0);
    pulse_done();
    frm_valid = 1'b1;   // next frame waits through the gap
    frm_last  = 1'b1;
    count_fills(n, r);
    check("R4 fill count non-last", n, 3 + 255 - int'(g));
    check("R6 ready low during fills", r, 0);
    check("R6 ready after gap", frm_ready, 1);
    check("R2 active between frames", tx_active, 1);
    @(negedge clk);
    frm_valid = 1'b0;
    frm_last  = 1'b0;
    check("R6 accepted after gap", frm_ready, 0);
    pulse_done();
    count_fills(n, r);
    check("R5 no extra fill on last", n, 3);
    count_hold(n);
    check("R5 hold after two frames", n, int'(h) * 4);
  endtask

  task automatic t_cfg_sample();
    int n, r;
    gap_cfg = 8'hFD;
    hold_cfg = 5'd2;
    send_frame(1'b0);
    gap_cfg = 8'hF0;
    hold_cfg = 5'd9;
    pulse_done();
    count_fills(n, r);
    check("R7 old gap used", n, 5);
    send_frame(1'b1);
    pulse_done();
    count_fills(n, r);
    check("R7 last fills", n, 3);
    count_hold(n);
    check("R7 old hold used", n, 8);
    send_frame(1'b0);
    pulse_done();
    count_fills(n, r);
    check("R7 new gap next message", n, 3 + 15);
    send_frame(1'b1);
    pulse_done();
    count_fills(n, r);
    count_hold(n);
    check("R7 new hold next message", n, 36);
  endtask

  task automatic t_stray_done();
    int n, r;
    pulse_done();
    check("R8 idle fill_req", fill_req, 0);
    check("R8 idle tx_active", tx_active, 0);
    gap_cfg = 8'hFF;
    hold_cfg = 5'd1;
    send_frame(1'b0);
    pulse_done();
    count_fills(n, r);
    pulse_done();
    @(negedge clk);
    check("R8 wait fill_req", fill_req, 0);
    check("R8 wait tx_active", tx_active, 1);
    check("R8 wait ready", frm_ready, 1);
    send_frame(1'b1);
    pulse_done();
    count_fills(n, r);
    check("R8 frame after stray done", n, 3);
    count_hold(n);
    check("R5 hold one step", n, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_last(5'd0);
    t_single_last(5'd5);
    t_single_last(5'd31);
    t_two_frames(8'hFF, 5'd0);
    t_two_frames(8'hFA, 5'd3);
    t_two_frames(8'h00, 5'd1);
    t_cfg_sample();
    t_stray_done();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule